// File: doc/BRIEF.md
# Programmable Waveform Bus Engine

This block masters an external parallel bus with a waveform that software defines. A small table of vectors is loaded through a write-only configuration port. Each vector sets the levels of three control outputs. It also names a condition on two ready inputs that must hold before the engine moves on to the next vector.

While a vector completes, it can pulse a strobe that advances an external FIFO to its next data value. It can also step an address counter. A start pulse runs the table from vector 0 until a vector flagged as last completes. That sequence is one bus transaction. The engine then raises a one-cycle done pulse and parks the control outputs at idle levels set from outside.

The transfer width (8 or 16 bits) is latched at start. It sets the address step. The engine also drives the 2-bit FIFO select it latched at start, for the whole transaction.

Top module: `wave_engine`

## Requirements
- R1: After synchronous reset the engine is idle: `busy` and `done` are 0, `fifo_adv` and `data_dir` are 0, `addr` is 0, and `ctl_out` equals `idle_ctl`.
- R2: A write with `cfg_we` high stores `cfg_data` into vector slot `cfg_addr`. Vector bit layout:
  - [2:0] control levels
  - [4:3] ready select, bit i includes `rdy_in[i]`
  - [6:5] wanted level of each ready input
  - [7] combine, 0 = all selected must match, 1 = any selected
  - [8] FIFO advance
  - [9] address step
  - [10] data direction
  - [11] last
- R3: A `start` seen while idle makes the engine busy on the next cycle, running vector 0. It also latches `addr_base` into `addr`, `fifo_sel_in` into `fifo_sel` and `bus16` into `wide_mode`. A `start` while busy is ignored and does not disturb the running vector or the address.
- R4: While a vector runs, `ctl_out` shows its control levels and `data_dir` shows its direction bit.
- R5: A vector whose ready select is 0 completes after exactly one clock.
- R6: A vector with a nonzero ready select completes in the first cycle its condition holds on the synchronised ready inputs, and holds otherwise. The condition uses the select, level and combine fields as laid out in R2.
- R7: Each ready input passes through two flops. A level applied just after a clock edge lets a waiting vector complete on the third rising edge after it is applied.
- R8: `fifo_adv` is high exactly in the completing cycle of a vector with its FIFO-advance bit set, and low at all other times.
- R9: When a vector with its address-step bit completes, `addr` grows by 1 in 8-bit mode or by 2 in 16-bit mode, modulo 2^ADDR_W.
- R10: One cycle after the last vector completes, `done` is high for one cycle and `ctl_out` returns to `idle_ctl`. Vectors after the last one are never run, and `busy` falls on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Vector write enable |
| cfg_addr | input | 3 | Vector slot to write |
| cfg_data | input | 12 | Vector contents |
| idle_ctl | input | 3 | Control levels while not running |
| start | input | 1 | Begin a transaction |
| bus16 | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| fifo_sel_in | input | 2 | FIFO to address during the transaction |
| addr_base | input | 9 | Starting address |
| rdy_in | input | 2 | Asynchronous ready inputs |
| ctl_out | output | 3 | Control outputs |
| data_dir | output | 1 | Direction of the running vector |
| wide_mode | output | 1 | Latched transfer width |
| fifo_sel | output | 2 | Latched FIFO select |
| fifo_adv | output | 1 | FIFO advance strobe |
| addr | output | 9 | Address counter |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench uses the defaults: 8 vector slots, a 9-bit address and two synchroniser stages. With only 8 slots and two ready inputs, it can sweep every select, level and combine setting against all four ready values. It can also sweep every position of the last vector in both widths.

Starting the address near the top of its 9-bit range makes the counter wrap in 16-bit runs. A held wait vector lets the bench count the synchroniser delay edge by edge and inject an ignored start.

// File: rtl/wfe_pkg.sv
package wfe_pkg;

    localparam int CTL_W = 3;
    localparam int RDY_N = 2;

    typedef struct packed {
        logic             last;
        logic             dir;
        logic             addr_step;
        logic             fifo_step;
        logic             any_mode;
        logic [RDY_N-1:0] want;
        logic [RDY_N-1:0] sel;
        logic [CTL_W-1:0] ctl;
    } vec_t;

    localparam int VEC_W = $bits(vec_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    function automatic logic [RDY_N-1:0] match_bits(input logic [RDY_N-1:0] lvl,
                                                    input logic [RDY_N-1:0] want);
        return ~(lvl ^ want);
    endfunction

endpackage

// File: rtl/wfe_vector_mem.sv
module wfe_vector_mem
    import wfe_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output vec_t             rd_vec
);

    vec_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (wr_en) begin
            slots[wr_idx] <= vec_t'(wr_data);
        end
    end

    assign rd_vec = slots[rd_idx];

endmodule

// File: rtl/wfe_rdy_sync.sv
module wfe_rdy_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         chain[s] <= '0;
                else if (s == 0) chain[s] <= async_in;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/wfe_cond.sv
module wfe_cond
    import wfe_pkg::*;
(
    input  logic [RDY_N-1:0] lvl,
    input  logic [RDY_N-1:0] sel,
    input  logic [RDY_N-1:0] want,
    input  logic             any_mode,
    output logic             met
);

    logic [RDY_N-1:0] hit;

    always_comb begin
        hit = match_bits(lvl, want);
        if (sel == '0)    met = 1'b1;
        else if (any_mode) met = |(hit & sel);
        else              met = &(hit | ~sel);
    end

endmodule

// File: rtl/wave_engine.sv
module wave_engine
    import wfe_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [VEC_W-1:0]  cfg_data,
    input  logic [CTL_W-1:0]  idle_ctl,
    input  logic              start,
    input  logic              bus16,
    input  logic [1:0]        fifo_sel_in,
    input  logic [ADDR_W-1:0] addr_base,
    input  logic [RDY_N-1:0]  rdy_in,
    output logic [CTL_W-1:0]  ctl_out,
    output logic              data_dir,
    output logic              wide_mode,
    output logic [1:0]        fifo_sel,
    output logic              fifo_adv,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seq_state_t        state;
    logic [IDX_W-1:0]  pc;
    vec_t              cur;
    logic [RDY_N-1:0]  rdy_s;
    logic              met;
    logic              step_now;
    logic [ADDR_W-1:0] incr;

    wfe_vector_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_idx(cfg_addr), .wr_data(cfg_data),
        .rd_idx(pc), .rd_vec(cur)
    );

    wfe_rdy_sync #(.WIDTH(RDY_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(rdy_in), .sync_out(rdy_s)
    );

    wfe_cond u_cond (
        .lvl(rdy_s), .sel(cur.sel), .want(cur.want),
        .any_mode(cur.any_mode), .met(met)
    );

    assign step_now = (state == ST_RUN) && met;
    assign incr     = wide_mode ? ADDR_W'(2) : ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pc        <= '0;
            addr      <= '0;
            fifo_sel  <= '0;
            wide_mode <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_RUN;
                    pc        <= '0;
                    addr      <= addr_base;
                    fifo_sel  <= fifo_sel_in;
                    wide_mode <= bus16;
                end
                ST_RUN: if (met) begin
                    if (cur.addr_step) addr <= addr + incr;
                    if (cur.last)      state <= ST_FIN;
                    else               pc <= (pc == LAST_IDX) ? '0 : pc + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ctl_out  = (state == ST_RUN) ? cur.ctl : idle_ctl;
    assign data_dir = (state == ST_RUN) && cur.dir;
    assign fifo_adv = step_now && cur.fifo_step;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);

    assert_start_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done && pc == '0 && addr == $past(addr_base)));

    assert_fifo_sel_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(fifo_sel));

    assert_no_wait_one_clock_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && cur.sel == '0) |=> (pc != $past(pc) || done));

    assert_fifo_strobe_running_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_adv |-> (busy && !done));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

// File: tb/wave_engine_bench.sv
module wave_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 9;
    localparam logic [2:0] IDLE_LVL = 3'b011;

    logic clk = 0, rst = 1, cfg_we = 0, start = 0, bus16 = 0;
    logic [2:0] cfg_addr = 0, idle_ctl = IDLE_LVL;
    logic [11:0] cfg_data = 0;
    logic [1:0] fifo_sel_in = 0, rdy_in = 0;
    logic [ADDR_W-1:0] addr_base = 0;
    logic [2:0] ctl_out;
    logic data_dir, wide_mode, fifo_adv, busy, done;
    logic [1:0] fifo_sel;
    logic [ADDR_W-1:0] addr;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_engine u_wave_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .idle_ctl(idle_ctl), .start(start), .bus16(bus16), .fifo_sel_in(fifo_sel_in),
        .addr_base(addr_base), .rdy_in(rdy_in), .ctl_out(ctl_out), .data_dir(data_dir),
        .wide_mode(wide_mode), .fifo_sel(fifo_sel), .fifo_adv(fifo_adv), .addr(addr),
        .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [11:0] mkvec(input logic [2:0] c, input logic [1:0] s,
        input logic [1:0] w, input logic o, input logic f, input logic a,
        input logic d, input logic l);
        return {l, d, a, f, o, w, s, c};
    endfunction

    task automatic wr(input int idx, input logic [11:0] v);
        cfg_we = 1; cfg_addr = 3'(idx); cfg_data = v;
        tick();
        cfg_we = 0;
    endtask

    task automatic go();
        start = 1;
        tick();
        start = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        tick();
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(ctl_out == IDLE_LVL, "R1 ctl idle", ctl_out, IDLE_LVL);
        chk(!fifo_adv && !data_dir && addr == 0, "R1 strobes/addr", addr, 0);

        // R6 sweep of every ready condition against every ready value
        for (int sel = 0; sel < 4; sel++)
        for (int want = 0; want < 4; want++)
        for (int anym = 0; anym < 2; anym++)
        for (int r = 0; r < 4; r++) begin
            logic exp_met;
            logic any_hit;
            logic all_hit;
            any_hit = 0; all_hit = 1;
            for (int i = 0; i < 2; i++) if (sel[i]) begin
                if (r[i] == want[i]) any_hit = 1; else all_hit = 0;
            end
            exp_met = (sel == 0) ? 1'b1 : (anym != 0 ? any_hit : all_hit);
            do_reset();
            wr(0, mkvec(3'b101, 2'(sel), 2'(want), anym[0], 0, 0, 0, 1));
            rdy_in = 2'(r);
            tick(); tick(); tick();
            go();
            chk(busy && ctl_out == 3'b101, "R2 R4 ctl running", ctl_out, 5);
            tick();
            if (exp_met)
                chk(done && ctl_out == IDLE_LVL, "R6 condition met", {done, ctl_out}, {1'b1, IDLE_LVL});
            else
                chk(!done && busy && ctl_out == 3'b101, "R6 condition waits", {done, ctl_out}, 5);
        end
        do_reset();
        rdy_in = 0;

        // Last-position sweep in both widths: R4 R5 R8 R9 R10
        for (int w = 0; w < 2; w++)
        for (int L = 0; L < 8; L++) begin
            int cnt;
            logic [ADDR_W-1:0] ea;
            for (int i = 0; i < 8; i++)
                wr(i, mkvec(3'((i*3+1)%8), 0, 0, 0, (i%2) != 0, (i%3) == 0, i >= 4, i == L));
            bus16 = w[0]; fifo_sel_in = 2'(L); addr_base = 9'h1FC;
            go();
            cnt = 0;
            bus16 = ~bus16; fifo_sel_in = ~fifo_sel_in;
            for (int k = 0; k <= L; k++) begin
                ea = ADDR_W'(32'h1FC + (w + 1) * cnt);
                chk(ctl_out == 3'((k*3+1)%8), "R4 R5 ctl per clock", ctl_out, (k*3+1)%8);
                chk(data_dir == (k >= 4), "R4 dir", data_dir, k >= 4);
                chk(fifo_adv == ((k%2) != 0), "R8 fifo strobe", fifo_adv, (k%2) != 0);
                chk(addr == ea, "R9 address", addr, ea);
                chk(wide_mode == w[0] && fifo_sel == 2'(L), "R3 latched", {wide_mode, fifo_sel}, {w[0], 2'(L)});
                chk(!done, "R10 no early done", done, 0);
                if ((k%3) == 0) cnt++;
                tick();
            end
            ea = ADDR_W'(32'h1FC + (w + 1) * cnt);
            chk(done && ctl_out == IDLE_LVL && !fifo_adv, "R10 done pulse", {done, ctl_out}, {1'b1, IDLE_LVL});
            chk(addr == ea, "R9 final address wrap", addr, ea);
            tick();
            chk(!done && !busy, "R10 back to idle", {done, busy}, 0);
        end

        // R7 synchroniser delay and R3 ignored start
        wr(0, mkvec(3'b001, 0, 0, 0, 0, 1, 0, 0));
        wr(1, mkvec(3'b010, 2'b01, 2'b01, 0, 1, 1, 0, 0));
        wr(2, mkvec(3'b100, 0, 0, 0, 0, 0, 0, 1));
        rdy_in = 0; bus16 = 0; addr_base = 9'h010;
        tick(); tick(); tick();
        go();
        chk(ctl_out == 3'b001, "R3 starts at vector 0", ctl_out, 1);
        tick();
        chk(ctl_out == 3'b010 && addr == 9'h011, "R7 waiting vector", ctl_out, 2);
        tick(); tick();
        go();
        chk(ctl_out == 3'b010 && addr == 9'h011 && busy, "R3 start while busy ignored", ctl_out, 2);
        rdy_in = 2'b01;
        tick();
        chk(ctl_out == 3'b010 && !fifo_adv, "R7 edge 1 still waiting", ctl_out, 2);
        tick();
        chk(ctl_out == 3'b010 && fifo_adv, "R7 edge 2 completes now", fifo_adv, 1);
        tick();
        chk(ctl_out == 3'b100 && addr == 9'h012, "R7 edge 3 advanced", ctl_out, 4);
        tick();
        chk(done, "R10 done after wait program", done, 1);
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule